// File: doc/BRIEF.md
# IPv4 Forwarding Header Rewriter

This block sits on the fast forwarding path of a router. It takes the leading 64-byte chunk of an Ethernet frame that carries IPv4, together with the result of an earlier route lookup: an output port index and the MAC address of the next hop. It returns the rewritten chunk three clock edges later. Later chunks of the same frame never pass through this block. The queue chosen for this first chunk carries the rest of the frame.

A chunk that passes every header check has its TTL lowered by one and its header checksum adjusted. Its destination MAC is replaced with the next-hop address, and its source MAC with the address of the chosen output port. A chunk that the fast path cannot handle goes to a slow-path queue untouched. This covers headers that carry options and packets whose TTL has run out. A malformed header is flagged for dropping. The MAC addresses of the output ports are held in a small register table, which is loaded through a configuration write port.

Byte numbering: byte 0 of the chunk is `in_chunk[511:504]` and byte k is `in_chunk[511-8k -: 8]`. Multi-byte fields are big-endian.

Top module: `ipv4_hdr_rewriter`

## Requirements
- R1: A chunk presented with `in_valid` high before a rising edge appears with `out_valid` high after the third rising edge, counting the edge that captures it. `out_valid` is high for one cycle per input chunk. Back-to-back chunks come out in consecutive cycles and in input order.
- R2: A header is malformed unless all of these hold: bytes 12-13 equal 0x0800, the high nibble of byte 14 is 4, the low nibble of byte 14 (header length in words) is at least 5, and bytes 16-17 are at least 20. A malformed header gives `out_drop`=1, `out_divert`=0, `out_queue`=0, and the chunk unchanged. This check takes precedence over every other outcome.
- R3: A well-formed header whose length nibble is above 5 gives `out_divert`=1, `out_drop`=0, `out_queue`=NUM_PORTS, and the chunk unchanged. Its checksum is not examined.
- R4: When the length nibble is 5, the one's-complement sum of the ten 16-bit words in bytes 14-33 must equal 0xFFFF. Otherwise the chunk is dropped as in R2, even if its TTL would divert it.
- R5: A valid option-free header whose TTL (byte 22) is 0 or 1 gives `out_divert`=1, `out_queue`=NUM_PORTS, and the chunk unchanged.
- R6: A forwarded chunk (both flags 0) leaves with byte 22 equal to the input TTL minus one.
- R7: A forwarded chunk leaves with bytes 24-25 equal to a full recomputation of the header checksum over the updated bytes 14-33.
- R8: A forwarded chunk leaves with bytes 0-5 equal to `in_nh_mac`.
- R9: A forwarded chunk leaves with bytes 6-11 equal to the table entry for `in_port`, and with `out_queue` equal to `in_port`.
- R10: A forwarded chunk leaves every byte other than 0-11, 22, 24 and 25 unchanged.
- R11: A `cfg_we` pulse at an edge stores `cfg_mac` for `cfg_port`. The table holds zero after reset. A chunk whose lookup happens in the cycle after its capture edge reads the table as it was before a write landing on that same edge.
- R12: While `rst_n` is low, `out_valid`, `out_drop` and `out_divert` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input chunk present |
| in_chunk | input | 512 | First 64-byte chunk of the frame |
| in_port | input | PORT_W (4) | Output port from route lookup |
| in_nh_mac | input | 48 | Next-hop MAC from route lookup |
| cfg_we | input | 1 | Port MAC table write strobe |
| cfg_port | input | PORT_W (4) | Table entry to write |
| cfg_mac | input | 48 | MAC written to the table |
| out_valid | output | 1 | Output chunk present |
| out_chunk | output | 512 | Rewritten or untouched chunk |
| out_queue | output | QUEUE_W (5) | Port index, NUM_PORTS for slow path, 0 on drop |
| out_divert | output | 1 | Frame goes to the slow-path processor |
| out_drop | output | 1 | Frame has a malformed header |

## Verification
Two of the block's functions can meet in one cycle: the table lookup for a chunk in its second stage, and a configuration write to the same table entry. The bench provokes this by capturing a chunk for port 5 and then asserting a write to port 5 in the very next cycle. The chunk must then carry the old source MAC. A second chunk sent after the write must carry the new one. The checks where outcomes compete (bad checksum with TTL 1, bad length with options) judge the precedence among drop, divert and forward.

// File: rtl/ipv4_rw_pkg.sv
package ipv4_rw_pkg;
    localparam int CHUNK_BYTES = 64;
    localparam int CHUNK_W     = CHUNK_BYTES * 8;
    localparam int MAC_W       = 48;
    localparam int HDR_BYTES   = 20;
    localparam int HDR_W       = HDR_BYTES * 8;
    localparam int HDR_WORDS   = HDR_BYTES / 2;
    localparam int TTL_WORD    = 4;
    localparam int CSUM_WORD   = 5;

    // byte offsets inside the chunk
    localparam int OFF_DST   = 0;
    localparam int OFF_SRC   = 6;
    localparam int OFF_ETYPE = 12;
    localparam int OFF_IP    = 14;
    localparam int OFF_TLEN  = 16;
    localparam int OFF_TTL   = 22;
    localparam int OFF_CSUM  = 24;

    // top bit position of each field
    localparam int P_DST   = CHUNK_W - 1 - 8 * OFF_DST;
    localparam int P_SRC   = CHUNK_W - 1 - 8 * OFF_SRC;
    localparam int P_ETYPE = CHUNK_W - 1 - 8 * OFF_ETYPE;
    localparam int P_IP    = CHUNK_W - 1 - 8 * OFF_IP;
    localparam int P_TLEN  = CHUNK_W - 1 - 8 * OFF_TLEN;
    localparam int P_TTL   = CHUNK_W - 1 - 8 * OFF_TTL;
    localparam int P_CSUM  = CHUNK_W - 1 - 8 * OFF_CSUM;

    typedef enum logic [1:0] {
        CLS_FWD  = 2'd0,
        CLS_SLOW = 2'd1,
        CLS_DROP = 2'd2
    } cls_e;

    function automatic logic [15:0] ones_add(input logic [15:0] a, input logic [15:0] b);
        logic [16:0] s;
        s = {1'b0, a} + {1'b0, b};
        return s[15:0] + {15'd0, s[16]};
    endfunction
endpackage

// File: rtl/ipv4_rw_csum.sv
module ipv4_rw_csum
    import ipv4_rw_pkg::*;
(
    input  logic [HDR_W-1:0] hdr,
    output logic             sum_ok,
    output logic [15:0]      csum_upd
);
    logic [15:0] acc;
    logic [15:0] old_word;
    logic [15:0] new_word;
    logic [15:0] hc;

    always_comb begin
        acc = 16'd0;
        for (int i = 0; i < HDR_WORDS; i++) begin
            acc = ones_add(acc, hdr[HDR_W-1-16*i -: 16]);
        end
        sum_ok = (acc == 16'hFFFF);

        // incremental update for the TTL/protocol word
        old_word = hdr[HDR_W-1-16*TTL_WORD -: 16];
        new_word = {old_word[15:8] - 8'd1, old_word[7:0]};
        hc       = hdr[HDR_W-1-16*CSUM_WORD -: 16];
        csum_upd = ~ones_add(ones_add(~hc, ~old_word), new_word);
    end
endmodule

// File: rtl/ipv4_rw_mactab.sv
module ipv4_rw_mactab
    import ipv4_rw_pkg::*;
#(
    parameter int NUM_PORTS = 16,
    localparam int PORT_W   = $clog2(NUM_PORTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [PORT_W-1:0] wr_idx,
    input  logic [MAC_W-1:0]  wr_mac,
    input  logic [PORT_W-1:0] rd_idx,
    output logic [MAC_W-1:0]  rd_mac
);
    logic [MAC_W-1:0] ent_vec [NUM_PORTS];

    for (genvar i = 0; i < NUM_PORTS; i++) begin : g_ent
        logic [MAC_W-1:0] ent_d;
        logic [MAC_W-1:0] ent_q;

        always_comb begin
            ent_d = ent_q;
            if (wr_en && (wr_idx == PORT_W'(i))) begin
                ent_d = wr_mac;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ent_q <= '0;
            end else begin
                ent_q <= ent_d;
            end
        end

        assign ent_vec[i] = ent_q;
    end

    always_comb begin
        rd_mac = '0;
        if (int'(rd_idx) < NUM_PORTS) begin
            rd_mac = ent_vec[rd_idx];
        end
    end

    AST_CFG_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (ent_vec[$past(wr_idx)] == $past(wr_mac))); // R11
endmodule

// File: rtl/ipv4_hdr_rewriter.sv
module ipv4_hdr_rewriter
    import ipv4_rw_pkg::*;
#(
    parameter int NUM_PORTS = 16,
    localparam int PORT_W   = $clog2(NUM_PORTS),
    localparam int QUEUE_W  = $clog2(NUM_PORTS + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [CHUNK_W-1:0] in_chunk,
    input  logic [PORT_W-1:0]  in_port,
    input  logic [MAC_W-1:0]   in_nh_mac,
    input  logic               cfg_we,
    input  logic [PORT_W-1:0]  cfg_port,
    input  logic [MAC_W-1:0]   cfg_mac,
    output logic               out_valid,
    output logic [CHUNK_W-1:0] out_chunk,
    output logic [QUEUE_W-1:0] out_queue,
    output logic               out_divert,
    output logic               out_drop
);
    typedef struct packed {
        logic               valid;
        logic [CHUNK_W-1:0] chunk;
        logic [PORT_W-1:0]  port;
        logic [MAC_W-1:0]   nh;
    } s1_t;

    typedef struct packed {
        logic               valid;
        cls_e               cls;
        logic [CHUNK_W-1:0] chunk;
        logic [PORT_W-1:0]  port;
        logic [MAC_W-1:0]   nh;
        logic [MAC_W-1:0]   src;
        logic [15:0]        csum;
    } s2_t;

    typedef struct packed {
        logic               valid;
        logic [CHUNK_W-1:0] chunk;
        logic [QUEUE_W-1:0] queue;
        logic               divert;
        logic               drop;
    } s3_t;

    s1_t s1_d, s1_q;
    s2_t s2_d, s2_q;
    s3_t s3_d, s3_q;

    logic             sum_ok;
    logic [15:0]      csum_upd;
    logic [MAC_W-1:0] port_mac;

    ipv4_rw_csum u_csum (
        .hdr      (s1_q.chunk[P_IP -: HDR_W]),
        .sum_ok   (sum_ok),
        .csum_upd (csum_upd)
    );

    ipv4_rw_mactab #(.NUM_PORTS(NUM_PORTS)) u_mactab (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (cfg_we),
        .wr_idx (cfg_port),
        .wr_mac (cfg_mac),
        .rd_idx (s1_q.port),
        .rd_mac (port_mac)
    );

    logic [15:0] etype;
    logic [7:0]  ver_ihl;
    logic [15:0] tlen;
    logic [7:0]  ttl;
    logic        hdr_ok;

    always_comb begin
        // stage 1: capture
        s1_d.valid = in_valid;
        s1_d.chunk = in_chunk;
        s1_d.port  = in_port;
        s1_d.nh    = in_nh_mac;

        // stage 2: classify, checksum, table lookup
        etype   = s1_q.chunk[P_ETYPE -: 16];
        ver_ihl = s1_q.chunk[P_IP -: 8];
        tlen    = s1_q.chunk[P_TLEN -: 16];
        ttl     = s1_q.chunk[P_TTL -: 8];
        hdr_ok  = (etype == 16'h0800) && (ver_ihl[7:4] == 4'd4) &&
                  (ver_ihl[3:0] >= 4'd5) && (tlen >= 16'd20);

        if (!hdr_ok) begin
            s2_d.cls = CLS_DROP;
        end else if (ver_ihl[3:0] != 4'd5) begin
            s2_d.cls = CLS_SLOW;
        end else if (!sum_ok) begin
            s2_d.cls = CLS_DROP;
        end else if (ttl <= 8'd1) begin
            s2_d.cls = CLS_SLOW;
        end else begin
            s2_d.cls = CLS_FWD;
        end
        s2_d.valid = s1_q.valid;
        s2_d.chunk = s1_q.chunk;
        s2_d.port  = s1_q.port;
        s2_d.nh    = s1_q.nh;
        s2_d.src   = port_mac;
        s2_d.csum  = csum_upd;

        // stage 3: rewrite
        s3_d.valid  = s2_q.valid;
        s3_d.chunk  = s2_q.chunk;
        s3_d.queue  = '0;
        s3_d.divert = 1'b0;
        s3_d.drop   = 1'b0;
        unique case (s2_q.cls)
            CLS_FWD: begin
                s3_d.chunk[P_DST -: MAC_W] = s2_q.nh;
                s3_d.chunk[P_SRC -: MAC_W] = s2_q.src;
                s3_d.chunk[P_TTL -: 8]     = s2_q.chunk[P_TTL -: 8] - 8'd1;
                s3_d.chunk[P_CSUM -: 16]   = s2_q.csum;
                s3_d.queue                 = QUEUE_W'(s2_q.port);
            end
            CLS_SLOW: begin
                s3_d.queue  = QUEUE_W'(NUM_PORTS);
                s3_d.divert = 1'b1;
            end
            default: begin
                s3_d.drop = 1'b1;
            end
        endcase
        if (!s2_q.valid) begin
            s3_d.divert = 1'b0;
            s3_d.drop   = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q <= '0;
            s2_q <= '0;
            s3_q <= '0;
        end else begin
            s1_q <= s1_d;
            s2_q <= s2_d;
            s3_q <= s3_d;
        end
    end

    assign out_valid  = s3_q.valid;
    assign out_chunk  = s3_q.chunk;
    assign out_queue  = s3_q.queue;
    assign out_divert = s3_q.divert;
    assign out_drop   = s3_q.drop;

    // edges since reset, so $past never reaches into reset
    logic [1:0] warm_q;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            warm_q <= 2'd0;
        end else if (warm_q != 2'd3) begin
            warm_q <= warm_q + 2'd1;
        end
    end

    AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q == 2'd3) |-> (out_valid == $past(in_valid, 3))); // R1
    AST_FWD_TTL: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q == 2'd3 && out_valid && !out_divert && !out_drop) |->
        (out_chunk[P_TTL -: 8] == $past(in_chunk[P_TTL -: 8], 3) - 8'd1)); // R6
    AST_FWD_QUEUE: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q == 2'd3 && out_valid && !out_divert && !out_drop) |->
        (out_queue == QUEUE_W'($past(in_port, 3)))); // R9
    AST_PASS_UNMOD: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q == 2'd3 && out_valid && (out_divert || out_drop)) |->
        (out_chunk == $past(in_chunk, 3))); // R2
    AST_DIVERT_QUEUE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_divert) |-> (out_queue == QUEUE_W'(NUM_PORTS) && !out_drop)); // R3
endmodule

// File: tb/ipv4_hdr_rewriter_tb.sv
module ipv4_hdr_rewriter_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NPORT = 16;
    localparam int NVEC = 14;

    // {ethertype[59:44], ver_ihl[43:36], total_len[35:20], ttl[19:12],
    //  port[11:8], bad_csum[7], class[6:5] (0 fwd,1 slow,2 drop), req[4:0]}
    localparam logic [59:0] VEC [NVEC] = '{
        {16'h0800, 8'h45, 16'd60,   8'd64,  4'd3,  1'b0, 2'd0, 5'd6},  // plain forward
        {16'h0800, 8'h45, 16'd20,   8'd2,   4'd0,  1'b0, 2'd0, 5'd6},  // lowest TTL forwarded
        {16'h0800, 8'h45, 16'd1500, 8'd255, 4'd15, 1'b0, 2'd0, 5'd6},  // top port
        {16'h0800, 8'h45, 16'd40,   8'd1,   4'd1,  1'b0, 2'd1, 5'd5},  // R5 TTL 1
        {16'h0800, 8'h45, 16'd40,   8'd0,   4'd1,  1'b0, 2'd1, 5'd5},  // R5 TTL 0
        {16'h0800, 8'h46, 16'd40,   8'd64,  4'd2,  1'b0, 2'd1, 5'd3},  // R3 options
        {16'h0800, 8'h4F, 16'd60,   8'd64,  4'd2,  1'b1, 2'd1, 5'd3},  // R3 options, bad sum ignored
        {16'h86DD, 8'h45, 16'd40,   8'd64,  4'd4,  1'b0, 2'd2, 5'd2},  // R2 ethertype
        {16'h0800, 8'h65, 16'd40,   8'd64,  4'd4,  1'b0, 2'd2, 5'd2},  // R2 version
        {16'h0800, 8'h44, 16'd40,   8'd64,  4'd4,  1'b0, 2'd2, 5'd2},  // R2 short IHL
        {16'h0800, 8'h45, 16'd19,   8'd64,  4'd4,  1'b0, 2'd2, 5'd2},  // R2 total length
        {16'h0800, 8'h45, 16'd40,   8'd64,  4'd6,  1'b1, 2'd2, 5'd4},  // R4 bad sum
        {16'h0800, 8'h45, 16'd40,   8'd1,   4'd6,  1'b1, 2'd2, 5'd4},  // R4 bad sum beats TTL
        {16'h0800, 8'h46, 16'd10,   8'd64,  4'd6,  1'b0, 2'd2, 5'd2}   // R2 length beats options
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [511:0] in_chunk = '0;
    logic [3:0]   in_port = '0;
    logic [47:0]  in_nh_mac = '0;
    logic         cfg_we = 1'b0;
    logic [3:0]   cfg_port = '0;
    logic [47:0]  cfg_mac = '0;
    logic         out_valid;
    logic [511:0] out_chunk;
    logic [4:0]   out_queue;
    logic         out_divert;
    logic         out_drop;

    int n_chk = 0;
    int n_fail = 0;
    logic [47:0] mac_model [NPORT];

    always #(CLK_PERIOD/2) clk = ~clk;

    ipv4_hdr_rewriter #(.NUM_PORTS(NPORT)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_chunk(in_chunk),
        .in_port(in_port), .in_nh_mac(in_nh_mac), .cfg_we(cfg_we),
        .cfg_port(cfg_port), .cfg_mac(cfg_mac), .out_valid(out_valid),
        .out_chunk(out_chunk), .out_queue(out_queue), .out_divert(out_divert),
        .out_drop(out_drop)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [511:0] act, input logic [511:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic string rname(input int r);
        case (r)
            2: return "R2";
            3: return "R3";
            4: return "R4";
            5: return "R5";
            default: return "R6";
        endcase
    endfunction

    function automatic logic [15:0] full_csum(input logic [511:0] c);
        logic [31:0] s = 32'd0;
        for (int w = 0; w < 10; w++) begin
            if (w != 5) s += 32'(c[511-8*(14+2*w) -: 16]);
        end
        s = {16'd0, s[15:0]} + {16'd0, s[31:16]};
        s = {16'd0, s[15:0]} + {16'd0, s[31:16]};
        return ~s[15:0];
    endfunction

    function automatic logic [511:0] make_chunk(input int idx, input logic [59:0] v);
        logic [511:0] c;
        for (int b = 0; b < 64; b++) c[511-8*b -: 8] = 8'(idx*29 + b*13 + 7);
        c[511-8*12 -: 16] = v[59:44];
        c[511-8*14 -: 8]  = v[43:36];
        c[511-8*16 -: 16] = v[35:20];
        c[511-8*22 -: 8]  = v[19:12];
        c[511-8*24 -: 16] = full_csum(c) ^ {15'd0, v[7]};
        return c;
    endfunction

    function automatic logic [511:0] fwd_chunk(input logic [511:0] c, input logic [47:0] nh,
                                               input logic [47:0] src);
        logic [511:0] r = c;
        r[511 -: 48]      = nh;
        r[511-8*6 -: 48]  = src;
        r[511-8*22 -: 8]  = c[511-8*22 -: 8] - 8'd1;
        r[511-8*24 -: 16] = full_csum(r);
        return r;
    endfunction

    task automatic drive(input logic [511:0] c, input int port, input logic [47:0] nh);
        in_valid  = 1'b1;
        in_chunk  = c;
        in_port   = 4'(port);
        in_nh_mac = nh;
    endtask

    // judge the output visible now against the expected class
    task automatic judge(input logic [511:0] c, input int port, input logic [47:0] nh,
                         input int cls, input string tag, input logic [47:0] src);
        logic [511:0] e;
        chk(out_valid == 1'b1, "R1", "out_valid at latency 3", 512'(out_valid), 512'd1);
        if (cls == 0) begin
            e = fwd_chunk(c, nh, src);
            chk(out_chunk[511-8*22 -: 8] == e[511-8*22 -: 8], "R6", "ttl",
                512'(out_chunk[511-8*22 -: 8]), 512'(e[511-8*22 -: 8]));
            chk(out_chunk[511-8*24 -: 16] == e[511-8*24 -: 16], "R7", "checksum",
                512'(out_chunk[511-8*24 -: 16]), 512'(e[511-8*24 -: 16]));
            chk(out_chunk[511 -: 48] == nh, "R8", "dst mac", 512'(out_chunk[511 -: 48]), 512'(nh));
            chk(out_chunk[511-8*6 -: 48] == src, "R9", "src mac",
                512'(out_chunk[511-8*6 -: 48]), 512'(src));
            chk({out_drop, out_divert, out_queue} == {2'b00, 5'(port)}, "R9", "flags/queue",
                512'({out_drop, out_divert, out_queue}), 512'({2'b00, 5'(port)}));
            chk(out_chunk == e, "R10", "whole chunk", out_chunk, e);
        end else begin
            chk({out_drop, out_divert, out_queue} ==
                ((cls == 1) ? {2'b01, 5'd16} : {2'b10, 5'd0}), tag, "flags/queue",
                512'({out_drop, out_divert, out_queue}),
                512'((cls == 1) ? {2'b01, 5'd16} : {2'b10, 5'd0}));
            chk(out_chunk == c, tag, "chunk unchanged", out_chunk, c);
        end
    endtask

    task automatic run_one(input logic [511:0] c, input int port, input logic [47:0] nh,
                           input int cls, input string tag, input logic [47:0] src);
        @(negedge clk); drive(c, port, nh);
        @(negedge clk); in_valid = 1'b0;
        @(negedge clk);
        chk(out_valid == 1'b0, "R1", "no output before latency", 512'(out_valid), 512'd0);
        @(negedge clk);
        judge(c, port, nh, cls, tag, src);
    endtask

    task automatic cfg_write(input int port, input logic [47:0] mac);
        @(negedge clk);
        cfg_we = 1'b1; cfg_port = 4'(port); cfg_mac = mac;
        @(negedge clk);
        cfg_we = 1'b0;
        mac_model[port] = mac;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL R1 watchdog: actual hung expected finished");
        summary();
        $finish;
    end

    initial begin
        logic [511:0] ca, cb;
        for (int p = 0; p < NPORT; p++) mac_model[p] = '0;

        // R12: reset state, even with a chunk offered
        @(negedge clk); drive(make_chunk(0, VEC[0]), 3, 48'h1);
        repeat (4) @(negedge clk);
        chk({out_valid, out_drop, out_divert} == 3'b000, "R12", "outputs in reset",
            512'({out_valid, out_drop, out_divert}), 512'd0);
        in_valid = 1'b0;
        rst_n = 1'b1;

        // R11: table is zero after reset
        run_one(make_chunk(40, VEC[0]), 7, 48'hA0_00_00_00_00_40, 0, "R11", 48'd0);

        for (int p = 0; p < NPORT; p++)
            cfg_write(p, 48'h02_00_5E_00_00_00 | 48'(p * 32'h00010101));

        // vector table walk
        for (int i = 0; i < NVEC; i++) begin
            automatic logic [59:0] v = VEC[i];
            automatic int port = int'(v[11:8]);
            run_one(make_chunk(i, v), port, 48'hA0_00_00_00_00_00 + 48'(i),
                    int'(v[6:5]), rname(int'(v[4:0])), mac_model[port]);
        end

        // R1: back-to-back chunks leave in order on consecutive cycles
        ca = make_chunk(20, VEC[0]);
        cb = make_chunk(21, VEC[2]);
        @(negedge clk); drive(ca, 3, 48'hB1);
        @(negedge clk); drive(cb, 15, 48'hB2);
        @(negedge clk); in_valid = 1'b0;
        @(negedge clk); judge(ca, 3, 48'hB1, 0, "R1", mac_model[3]);
        @(negedge clk); judge(cb, 15, 48'hB2, 0, "R1", mac_model[15]);
        @(negedge clk);
        chk(out_valid == 1'b0, "R1", "single valid per chunk", 512'(out_valid), 512'd0);

        // R11: write to port 5 on the same edge as the chunk's lookup
        ca = make_chunk(30, VEC[0]);
        @(negedge clk); drive(ca, 5, 48'hC1);
        @(negedge clk); in_valid = 1'b0;
        cfg_we = 1'b1; cfg_port = 4'd5; cfg_mac = 48'hDE_AD_00_00_00_05;
        @(negedge clk); cfg_we = 1'b0;
        @(negedge clk); judge(ca, 5, 48'hC1, 0, "R11", mac_model[5]);
        mac_model[5] = 48'hDE_AD_00_00_00_05;
        run_one(make_chunk(31, VEC[0]), 5, 48'hC2, 0, "R11", mac_model[5]);

        summary();
        $finish;
    end
endmodule